// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a shared, open-drain serial interrupt line that runs on the PCI clock. Each cycle opens with a start pulse: the host pulls the line low for a programmable number of clocks. The host then releases the line and steps through a fixed train of three-clock data frames. In each frame the line is sampled once, and a low level means that the source owning that slot is asserting its interrupt. The cycle closes with a host-driven stop pulse. The width of that pulse tells every device on the line which mode applies next: continuous or quiet.

In continuous mode the host opens the next cycle by itself after a programmable idle gap. In quiet mode the host leaves the line alone until some device pulls it low to ask for a cycle, and only then drives its own start pulse. The rebuilt interrupt vector is published once per cycle, with a one-clock done strobe. The pad itself is modelled as a drive-low enable plus the sampled line level. Pull-up behaviour and routing of the interrupts onward are handled elsewhere.

States: IDLE (line released, gap counting or waiting for a request), START (host drives low), SAMP, RECOV and TURN (the three clocks of a data frame), STOP (host drives low), STOP_REC (host releases) and STOP_TURN (done strobe). Transitions:
- IDLE→START happens when the gap has elapsed in continuous mode, or when the line is seen low in quiet mode.
- START→SAMP happens when the start width is reached.
- The frame states run SAMP→RECOV→TURN.
- TURN→SAMP is taken for the next frame, and TURN→STOP after the last frame.
- STOP→STOP_REC happens when the stop width is reached. STOP_REC→STOP_TURN always follows.
- STOP_TURN→START is taken in continuous mode with a zero gap. Otherwise STOP_TURN→IDLE.

Top module: `serirq_host`

## Requirements
- R1: While reset is held, `drive_low` is 0, `cycle_done` is 0 and `irq_levels` is all zeros; after reset the mode is continuous, so the host opens a cycle without being asked.
- R2: The start pulse holds `drive_low` high for `start_len` consecutive clocks, with values below 4 treated as 4 and values above 8 treated as 8.
- R3: After the start pulse come NFRAMES (default 17) frames of exactly three clocks each (sample, recovery, turn-around), during which `drive_low` stays 0.
- R4: Bit k of `irq_levels` is 1 when the line was low in the sample clock of frame k and 0 when it was high; bits 0 to 15 are IRQ0 to IRQ15 and bit 16 is the I/O channel check slot.
- R5: The stop pulse holds `drive_low` high for 3 clocks when `continuous` is 1 and 2 clocks when it is 0, with `continuous` taken in the turn-around clock of the last frame; that value becomes the mode for the following idle period.
- R6: After the stop pulse the host releases the line for one recovery clock with `cycle_done` 0, then in the turn-around clock `cycle_done` is 1 for exactly one clock.
- R7: `irq_levels` changes only as the turn-around clock of a stop frame begins; from then on it holds the new vector through the whole next cycle.
- R8: In continuous mode, `drive_low` stays 0 for exactly `idle_gap` clocks after the done clock before the next start pulse; a gap of 0 starts the pulse right after the done clock.
- R9: In quiet mode the host keeps `drive_low` at 0 while the line is high, and begins its start pulse in the clock after it samples the line low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_len | input | LEN_W (4) | Requested start pulse width in clocks, clamped to 4..8 |
| idle_gap | input | GAP_W (4) | Idle clocks between cycles in continuous mode |
| continuous | input | 1 | 1 selects continuous mode, 0 quiet mode, for the next stop pulse |
| line_in | input | 1 | Sampled level of the shared line |
| drive_low | output | 1 | 1 enables the open-drain pull-down of the line |
| irq_levels | output | NFRAMES (17) | Interrupt state per frame, 1 = asserted |
| cycle_done | output | 1 | One-clock strobe marking the end of a cycle |

## Verification
The bench builds the block with its default parameters: 17 frames, a 4-bit start width field and a 4-bit idle gap field. With these widths, requested start widths of 2 and 12 can be applied, so both clamp limits are exercised alongside in-range widths. A zero gap, a gap of several clocks and quiet-mode waits of a dozen clocks are all reachable. The I/O channel check slot in bit 16 is driven both alone and together with IRQ0 and IRQ15.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_SAMP,
        S_RECOV,
        S_TURN,
        S_STOP,
        S_STOP_REC,
        S_STOP_TURN
    } sirq_state_t;

    localparam int START_MIN  = 4;
    localparam int START_MAX  = 8;
    localparam int STOP_QUIET = 2;
    localparam int STOP_CONT  = 3;

endpackage

// File: rtl/serirq_seq.sv
module serirq_seq
    import serirq_pkg::*;
#(
    parameter int NFRAMES = 17,
    parameter int LEN_W   = 4,
    parameter int GAP_W   = 4,
    localparam int FRAME_W = $clog2(NFRAMES),
    localparam int CNT_W   = (LEN_W > GAP_W) ? LEN_W : GAP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEN_W-1:0]   start_len,
    input  logic [GAP_W-1:0]   idle_gap,
    input  logic               continuous,
    input  logic               line_in,
    output logic               drive_low,
    output logic               sample_en,
    output logic [FRAME_W-1:0] frame_idx,
    output logic               publish,
    output logic               cycle_done
);

    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NFRAMES - 1);

    sirq_state_t        state, state_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic [FRAME_W-1:0] frame, frame_n;
    logic               mode_q, mode_n;

    logic [CNT_W-1:0]   len_eff;
    logic [CNT_W-1:0]   stop_len;
    logic [CNT_W:0]     cnt_inc;
    logic [CNT_W:0]     gap_ext;

    // Clamp the requested start width into the legal window.
    always_comb begin
        if (start_len < LEN_W'(START_MIN))
            len_eff = CNT_W'(START_MIN);
        else if (start_len > LEN_W'(START_MAX))
            len_eff = CNT_W'(START_MAX);
        else
            len_eff = CNT_W'(start_len);
    end

    assign stop_len = mode_q ? CNT_W'(STOP_CONT) : CNT_W'(STOP_QUIET);
    assign cnt_inc  = {1'b0, cnt} + 1'b1;
    assign gap_ext  = (CNT_W+1)'(idle_gap);

    // Next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        frame_n = frame;
        mode_n  = mode_q;
        unique case (state)
            S_IDLE: begin
                if (mode_q) begin
                    if (cnt_inc >= gap_ext) begin
                        state_n = S_START;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_inc[CNT_W-1:0];
                    end
                end else if (!line_in) begin
                    state_n = S_START;
                    cnt_n   = '0;
                end
            end
            S_START: begin
                if (cnt == len_eff - 1'b1) begin
                    state_n = S_SAMP;
                    cnt_n   = '0;
                    frame_n = '0;
                end else begin
                    cnt_n = cnt_inc[CNT_W-1:0];
                end
            end
            S_SAMP:  state_n = S_RECOV;
            S_RECOV: state_n = S_TURN;
            S_TURN: begin
                if (frame == LAST_FRAME) begin
                    state_n = S_STOP;
                    mode_n  = continuous;
                    cnt_n   = '0;
                end else begin
                    frame_n = frame + 1'b1;
                    state_n = S_SAMP;
                end
            end
            S_STOP: begin
                if (cnt == stop_len - 1'b1) begin
                    state_n = S_STOP_REC;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_inc[CNT_W-1:0];
                end
            end
            S_STOP_REC: state_n = S_STOP_TURN;
            S_STOP_TURN: begin
                cnt_n   = '0;
                state_n = (mode_q && idle_gap == '0) ? S_START : S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            frame  <= '0;
            mode_q <= 1'b1;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            frame  <= frame_n;
            mode_q <= mode_n;
        end
    end

    // Outputs
    always_comb begin
        drive_low  = 1'b0;
        sample_en  = 1'b0;
        publish    = 1'b0;
        cycle_done = 1'b0;
        unique case (state)
            S_START, S_STOP: drive_low  = 1'b1;
            S_SAMP:          sample_en  = 1'b1;
            S_STOP_REC:      publish    = 1'b1;
            S_STOP_TURN:     cycle_done = 1'b1;
            default: ;
        endcase
    end

    assign frame_idx = frame;

    p_start_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START) |-> (cnt < CNT_W'(START_MAX)));

    p_frame_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SAMP) |-> (frame <= LAST_FRAME));

    p_frame_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SAMP) |=> (state == S_RECOV) ##1 (state == S_TURN));

    p_stop_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP) |-> (cnt < CNT_W'(STOP_CONT)));

    p_stop_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP_REC) |=> (state == S_STOP_TURN));

    p_quiet_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !mode_q && line_in) |=> (state == S_IDLE));

endmodule

// File: rtl/serirq_capture.sv
module serirq_capture #(
    parameter int NFRAMES = 17,
    localparam int FRAME_W = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_en,
    input  logic [FRAME_W-1:0] frame_idx,
    input  logic               line_in,
    input  logic               publish,
    output logic [NFRAMES-1:0] irq_levels
);

    logic [NFRAMES-1:0] shadow;

    for (genvar k = 0; k < NFRAMES; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[k] <= 1'b0;
            else if (sample_en && frame_idx == FRAME_W'(k))
                shadow[k] <= !line_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_levels <= '0;
        else if (publish)
            irq_levels <= shadow;
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !publish |=> $stable(irq_levels));

endmodule

// File: rtl/serirq_host.sv
module serirq_host #(
    parameter int NFRAMES = 17,
    parameter int LEN_W   = 4,
    parameter int GAP_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEN_W-1:0]   start_len,
    input  logic [GAP_W-1:0]   idle_gap,
    input  logic               continuous,
    input  logic               line_in,
    output logic               drive_low,
    output logic [NFRAMES-1:0] irq_levels,
    output logic               cycle_done
);

    localparam int FRAME_W = $clog2(NFRAMES);

    logic               sample_en;
    logic               publish;
    logic [FRAME_W-1:0] frame_idx;

    serirq_seq #(
        .NFRAMES (NFRAMES),
        .LEN_W   (LEN_W),
        .GAP_W   (GAP_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_len  (start_len),
        .idle_gap   (idle_gap),
        .continuous (continuous),
        .line_in    (line_in),
        .drive_low  (drive_low),
        .sample_en  (sample_en),
        .frame_idx  (frame_idx),
        .publish    (publish),
        .cycle_done (cycle_done)
    );

    serirq_capture #(
        .NFRAMES (NFRAMES)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .frame_idx  (frame_idx),
        .line_in    (line_in),
        .publish    (publish),
        .irq_levels (irq_levels)
    );

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    p_no_drive_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> !drive_low);

endmodule

// File: tb/serirq_host_test.sv
`timescale 1ns/1ps
module serirq_host_test;

    localparam int NF = 17;
    localparam int NV = 6;

    localparam bit          CONT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [3:0]  SLEN [NV] = '{4'd4, 4'd8, 4'd2, 4'd6, 4'd12, 4'd5};
    localparam logic [3:0]  GAP  [NV] = '{4'd3, 4'd0, 4'd0, 4'd5, 4'd2, 4'd1};
    localparam logic [16:0] PAT  [NV] = '{17'h00002, 17'h1FFFF, 17'h10000,
                                          17'h0A5A5, 17'h00000, 17'h18001};
    localparam int          XLEN [NV] = '{4, 8, 4, 6, 8, 5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  start_len = 4'd4;
    logic [3:0]  idle_gap = 4'd3;
    logic        continuous = 1'b1;
    logic        slave_low = 1'b0;
    logic        line;
    logic        drive_low;
    logic [16:0] irq_levels;
    logic        cycle_done;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    assign line = !(drive_low || slave_low);

    serirq_host uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_len  (start_len),
        .idle_gap   (idle_gap),
        .continuous (continuous),
        .line_in    (line),
        .drive_low  (drive_low),
        .irq_levels (irq_levels),
        .cycle_done (cycle_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            summary();
            $finish;
        end
    end

    initial begin
        int          cnt;
        logic [16:0] prev_exp;
        prev_exp = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(drive_low == 1'b0, "R1 drive_low in reset", int'(drive_low), 0);
        chk(cycle_done == 1'b0, "R1 cycle_done in reset", int'(cycle_done), 0);
        chk(irq_levels == '0, "R1 irq_levels in reset", int'(irq_levels), 0);

        start_len  = SLEN[0];
        idle_gap   = GAP[0];
        continuous = CONT[0];
        rst_n = 1'b1;

        // R1: continuous after reset, a cycle opens by itself
        cnt = 0;
        while (!drive_low && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        chk(drive_low == 1'b1, "R1 self-started cycle after reset", int'(drive_low), 1);

        for (int i = 0; i < NV; i++) begin
            if (i > 0) begin
                if (CONT[i-1]) begin
                    // R8: idle gap in continuous mode
                    cnt = 0;
                    @(negedge clk);
                    while (!drive_low && cnt < 40) begin
                        cnt++;
                        @(negedge clk);
                    end
                    chk(cnt == int'(GAP[i]), "R8 idle gap clocks", cnt, int'(GAP[i]));
                end else begin
                    // R9: quiet mode waits for a request
                    cnt = 0;
                    for (int w = 0; w < 12; w++) begin
                        @(negedge clk);
                        if (drive_low) cnt++;
                    end
                    chk(cnt == 0, "R9 no drive while line high in quiet mode", cnt, 0);
                    slave_low = 1'b1;
                    @(negedge clk);
                    slave_low = 1'b0;
                    chk(drive_low == 1'b1, "R9 start follows request", int'(drive_low), 1);
                end
            end

            // R2: start pulse width
            cnt = 0;
            while (drive_low && cnt < 40) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == XLEN[i], "R2 start pulse width", cnt, XLEN[i]);

            // R7: output still holds the previous vector mid-cycle
            chk(irq_levels == prev_exp, "R7 levels held during cycle",
                int'(irq_levels), int'(prev_exp));

            // R3/R4: frames, slave drives its slots in sample clocks
            cnt = 0;
            for (int k = 0; k < NF; k++) begin
                slave_low = PAT[i][k];
                if (drive_low) cnt++;
                @(negedge clk);
                slave_low = 1'b0;
                if (drive_low) cnt++;
                @(negedge clk);
                if (drive_low) cnt++;
                @(negedge clk);
            end
            chk(cnt == 0, "R3 host released line during frames", cnt, 0);

            // R5: stop pulse width
            cnt = 0;
            while (drive_low && cnt < 40) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == (CONT[i] ? 3 : 2), "R5 stop pulse width", cnt, CONT[i] ? 3 : 2);

            // R6: recovery clock then done strobe
            chk(cycle_done == 1'b0, "R6 no done in recovery clock", int'(cycle_done), 0);
            @(negedge clk);
            chk(cycle_done == 1'b1, "R6 done in turn-around clock", int'(cycle_done), 1);
            chk(irq_levels == PAT[i], "R4 captured interrupt levels",
                int'(irq_levels), int'(PAT[i]));
            prev_exp = PAT[i];

            if (i + 1 < NV) begin
                start_len  = SLEN[i+1];
                idle_gap   = GAP[i+1];
                continuous = CONT[i+1];
            end
        end

        // R6: done is a single-clock strobe
        @(negedge clk);
        chk(cycle_done == 1'b0, "R6 done lasts one clock", int'(cycle_done), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule